// File: doc/BRIEF.md
# SPI Interrupt Status Aggregator

This block is the interrupt section of a byte-oriented SPI controller. It keeps three software-visible registers: a status register of sticky event flags, a per-bit enable mask, and a global enable word whose top bit switches the whole interrupt on or off. The FIFO and shifter logic next to it sends single-cycle event pulses, and those pulses set status flags. Software changes flags by writing a toggle pattern to the status register: every 1 in the written word inverts that flag. A write of the flags that were read back therefore clears them.

The block also watches the receive FIFO's level. On every register access, whatever the address, it re-asserts the receive-not-empty and receive-full flags while the FIFO holds data or is full. A low level never clears these flags. The single interrupt output is registered. It is high when any flag is both set and enabled and the global switch is on.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset the status, enable and global registers read 0 and `irqOut` is low.
- R2: A write to status offset 0x20 inverts each stored status bit whose written bit is 1 and leaves every other bit unchanged.
- R3: Event pulses set sticky status bits. `evByteDone` sets bit 2 (transmit empty) and bit 8 (receive not empty). `evTxUnderrun` sets bit 3, `evRxFull` sets bit 4, `evRxOverrun` sets bit 5 (a byte was dropped) and `evTxHalfEmpty` sets bit 6.
- R4: An event pulse in the same cycle as a status write is ORed in after the toggle. If the write toggles a set bit off while its event fires, the bit stays 1.
- R5: In a cycle with a register access (`regWrEn` or `regRdEn`), `rxLvlNotEmpty` high sets status bit 8 and `rxLvlFull` high sets status bit 4. Without an access the levels have no effect, and a low level never clears either bit.
- R6: `irqOut` is a register. At each clock edge it takes the value of (status AND enable) being nonzero while global bit 31 is 1, computed from the register values that this same edge stores.
- R7: Only bit 31 of the global register gates the interrupt. With bit 31 at 0, `irqOut` stays low whatever the other global bits hold.
- R8: The enable register at 0x28 and the global register at 0x1C store the full written word and read it back.
- R9: A read returns the value stored before the edge at which the read takes effect. A write to any other offset changes none of the three registers, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational, valid while regRdEn is high |
| evByteDone | input | 1 | Pulse: one byte was shifted |
| evTxUnderrun | input | 1 | Pulse: transmit underrun |
| evRxFull | input | 1 | Pulse: receive FIFO became full |
| evRxOverrun | input | 1 | Pulse: received byte dropped |
| evTxHalfEmpty | input | 1 | Pulse: transmit FIFO half empty |
| rxLvlNotEmpty | input | 1 | Level: receive FIFO holds data |
| rxLvlFull | input | 1 | Level: receive FIFO is full |
| irqOut | output | 1 | Level interrupt output |

## Verification
The case that is hardest to reach from the ports is a level flag that must appear only through a register access. The only view of status is a read, and that read is itself an access. The bench raises the FIFO levels while the bus is idle, then reads twice. The first read must still show the old value and the second must show the flags. It then drops the levels and reads again to confirm the flags are still set. The same-edge collision between a toggling write and an event pulse is driven in a single bench cycle, so that the OR-after-toggle ordering is what decides the result.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_GLOBAL = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrEnable;
    logic   wrGlobal;
    logic   access;
    rdSel_e rdSel;
  } ctrlStrobes_t;

  localparam int BIT_TX_EMPTY    = 2;
  localparam int BIT_TX_UNDERRUN = 3;
  localparam int BIT_RX_FULL     = 4;
  localparam int BIT_RX_OVERRUN  = 5;
  localparam int BIT_TX_HALF     = 6;
  localparam int BIT_RX_NOTEMPTY = 8;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OFS_GLOBAL = 'h1C,
  parameter int OFS_STATUS = 'h20,
  parameter int OFS_ENABLE = 'h28
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(OFS_GLOBAL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

  logic hitStatus, hitEnable, hitGlobal;

  always_comb begin
    hitStatus = (regAddr == A_STATUS);
    hitEnable = (regAddr == A_ENABLE);
    hitGlobal = (regAddr == A_GLOBAL);

    strobes.wrStatus = regWrEn && hitStatus;
    strobes.wrEnable = regWrEn && hitEnable;
    strobes.wrGlobal = regWrEn && hitGlobal;
    strobes.access   = regWrEn || regRdEn;

    if (hitStatus)      strobes.rdSel = SEL_STATUS;
    else if (hitEnable) strobes.rdSel = SEL_ENABLE;
    else if (hitGlobal) strobes.rdSel = SEL_GLOBAL;
    else                strobes.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evByteDone,
  input  logic              evTxUnderrun,
  input  logic              evRxFull,
  input  logic              evRxOverrun,
  input  logic              evTxHalfEmpty,
  input  logic              rxLvlNotEmpty,
  input  logic              rxLvlFull,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] enableQ,
  output logic [DATA_W-1:0] globalQ,
  output logic              irqQ
);
  localparam int GIE_BIT = DATA_W - 1;

  logic [DATA_W-1:0] eventSet, levelSet, toggled;
  logic [DATA_W-1:0] statusD, enableD, globalD;

  always_comb begin
    eventSet = '0;
    eventSet[BIT_TX_EMPTY]    = evByteDone;
    eventSet[BIT_RX_NOTEMPTY] = evByteDone;
    eventSet[BIT_TX_UNDERRUN] = evTxUnderrun;
    eventSet[BIT_RX_FULL]     = evRxFull;
    eventSet[BIT_RX_OVERRUN]  = evRxOverrun;
    eventSet[BIT_TX_HALF]     = evTxHalfEmpty;

    levelSet = '0;
    levelSet[BIT_RX_NOTEMPTY] = strobes.access && rxLvlNotEmpty;
    levelSet[BIT_RX_FULL]     = strobes.access && rxLvlFull;

    toggled = strobes.wrStatus ? (statusQ ^ wrData) : statusQ;
    statusD = toggled | eventSet | levelSet;
    enableD = strobes.wrEnable ? wrData : enableQ;
    globalD = strobes.wrGlobal ? wrData : globalQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      globalQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusD;
      enableQ <= enableD;
      globalQ <= globalD;
      irqQ    <= (|(statusD & enableD)) && globalD[GIE_BIT];
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_STATUS: rdData = statusQ;
      SEL_ENABLE: rdData = enableQ;
      SEL_GLOBAL: rdData = globalQ;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int OFS_GLOBAL = 'h1C,
  parameter int OFS_STATUS = 'h20,
  parameter int OFS_ENABLE = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evByteDone,
  input  logic              evTxUnderrun,
  input  logic              evRxFull,
  input  logic              evRxOverrun,
  input  logic              evTxHalfEmpty,
  input  logic              rxLvlNotEmpty,
  input  logic              rxLvlFull,
  output logic              irqOut
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] statusQ, enableQ, globalQ;

  spi_irq_ctrl #(
    .ADDR_W(ADDR_W), .OFS_GLOBAL(OFS_GLOBAL),
    .OFS_STATUS(OFS_STATUS), .OFS_ENABLE(OFS_ENABLE)
  ) i_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .strobes(strobes)
  );

  spi_irq_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .evByteDone(evByteDone), .evTxUnderrun(evTxUnderrun), .evRxFull(evRxFull),
    .evRxOverrun(evRxOverrun), .evTxHalfEmpty(evTxHalfEmpty),
    .rxLvlNotEmpty(rxLvlNotEmpty), .rxLvlFull(rxLvlFull),
    .rdData(regRdData), .statusQ(statusQ), .enableQ(enableQ),
    .globalQ(globalQ), .irqQ(irqOut)
  );
endmodule

// File: rtl/spi_irq_agg_chk.sv
module spi_irq_agg_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int OFS_STATUS = 'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              evTxUnderrun,
  input logic              rxLvlNotEmpty,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ,
  input logic [DATA_W-1:0] globalQ,
  input logic              irqOut
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  // R6
  irq_matches_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((|(statusQ & enableQ)) && globalQ[DATA_W-1]));

  // R7
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> globalQ[DATA_W-1]);

  // R3
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    evTxUnderrun |=> statusQ[3]);

  // R5
  level_on_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((regWrEn || regRdEn) && rxLvlNotEmpty) |=> statusQ[8]);

  // R2
  toggle_bit3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_STATUS && !evTxUnderrun)
      |=> statusQ[3] == ($past(statusQ[3]) ^ $past(regWrData[3])));

  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(enableQ) && $stable(globalQ)));
endmodule

bind spi_irq_agg spi_irq_agg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_STATUS(OFS_STATUS)
) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .evTxUnderrun(evTxUnderrun),
  .rxLvlNotEmpty(rxLvlNotEmpty), .statusQ(statusQ), .enableQ(enableQ),
  .globalQ(globalQ), .irqOut(irqOut)
);

// File: tb/test_spi_irq_agg.sv
module test_spi_irq_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evByteDone = 0, evTxUnderrun = 0, evRxFull = 0;
  logic        evRxOverrun = 0, evTxHalfEmpty = 0;
  logic        rxLvlNotEmpty = 0, rxLvlFull = 0;
  logic        irqOut;
  int compared = 0, mismatched = 0;
  bit done = 0;

  localparam logic [7:0] A_GLB = 8'h1C, A_STS = 8'h20, A_ENA = 8'h28;

  always #10 clk = ~clk;

  spi_irq_agg i_spi_irq_agg (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evByteDone(evByteDone), .evTxUnderrun(evTxUnderrun), .evRxFull(evRxFull),
    .evRxOverrun(evRxOverrun), .evTxHalfEmpty(evTxHalfEmpty),
    .rxLvlNotEmpty(rxLvlNotEmpty), .rxLvlFull(rxLvlFull), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    #1 check(req, regRdData, exp);
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evByteDone = 1;
      1: evTxUnderrun = 1;
      2: evRxFull = 1;
      3: evRxOverrun = 1;
      default: evTxHalfEmpty = 1;
    endcase
    @(negedge clk);
    {evByteDone, evTxUnderrun, evRxFull, evRxOverrun, evTxHalfEmpty} = '0;
  endtask

  task automatic testReset();
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    regRead("R1 status", A_STS, 32'h0);
    regRead("R1 enable", A_ENA, 32'h0);
    regRead("R1 global", A_GLB, 32'h0);
  endtask

  task automatic testEvents();
    pulse(0); regRead("R3 byteDone", A_STS, 32'h104);
    regWrite(A_STS, 32'h104); regRead("R2 clear", A_STS, 32'h0);
    pulse(1); regRead("R3 underrun", A_STS, 32'h08);
    pulse(3); regRead("R3 overrun", A_STS, 32'h28);
    pulse(4); regRead("R3 halfEmpty", A_STS, 32'h68);
    pulse(2); regRead("R3 rxFull", A_STS, 32'h78);
    regWrite(A_STS, 32'h78); regRead("R2 clear all", A_STS, 32'h0);
  endtask

  task automatic testToggle();
    regWrite(A_STS, 32'h8000_0003); regRead("R2 set", A_STS, 32'h8000_0003);
    regWrite(A_STS, 32'h0000_0001); regRead("R2 partial", A_STS, 32'h8000_0002);
    regWrite(A_STS, 32'h8000_0002); regRead("R2 zero", A_STS, 32'h0);
  endtask

  task automatic testCollision();
    regWrite(A_STS, 32'h8);
    @(negedge clk);
    regWrEn = 1; regAddr = A_STS; regWrData = 32'h8; evTxUnderrun = 1;
    @(negedge clk);
    regWrEn = 0; evTxUnderrun = 0;
    regRead("R4 event wins", A_STS, 32'h8);
    regWrite(A_STS, 32'h8); regRead("R4 cleared", A_STS, 32'h0);
  endtask

  task automatic testLevels();
    @(negedge clk);
    rxLvlNotEmpty = 1; rxLvlFull = 1;
    repeat (3) @(negedge clk);
    regRead("R5 idle no effect", A_STS, 32'h0);
    regRead("R5 set by access", A_STS, 32'h110);
    rxLvlNotEmpty = 0; rxLvlFull = 0;
    regRead("R5 not cleared", A_STS, 32'h110);
    rxLvlNotEmpty = 1;
    regWrite(A_STS, 32'h110); regRead("R5 reasserted", A_STS, 32'h100);
    rxLvlNotEmpty = 0;
    regWrite(A_STS, 32'h100); regRead("R5 clear", A_STS, 32'h0);
  endtask

  task automatic testIrq();
    regWrite(A_ENA, 32'h0000_0008);
    regWrite(A_GLB, 32'h8000_0000);
    regRead("R8 enable", A_ENA, 32'h8);
    regRead("R8 global", A_GLB, 32'h8000_0000);
    check("R6 idle", {31'b0, irqOut}, 32'h0);
    pulse(4);
    check("R6 masked bit", {31'b0, irqOut}, 32'h0);
    pulse(1);
    check("R6 rise", {31'b0, irqOut}, 32'h1);
    regWrite(A_GLB, 32'h7FFF_FFFF);
    check("R7 gated", {31'b0, irqOut}, 32'h0);
    regWrite(A_GLB, 32'h8000_0000);
    check("R7 ungated", {31'b0, irqOut}, 32'h1);
    regWrite(A_STS, 32'h48);
    check("R6 fall", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testOtherAddr();
    regWrite(8'h40, 32'hFFFF_FFFF);
    regRead("R9 status", A_STS, 32'h0);
    regRead("R9 enable", A_ENA, 32'h8);
    regRead("R9 global", A_GLB, 32'h8000_0000);
    regRead("R9 other read", 8'h40, 32'h0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testEvents();
    testToggle();
    testCollision();
    testLevels();
    testIrq();
    testOtherAddr();
    done = 1;
    finishRun();
  end
endmodule